// File: doc/BRIEF.md
# Compacted State-Save Fault Checker

This block decides, for one compacted processor-state save instruction, whether execution may go on or which exception has to be taken. It looks at the feature-support flags, the OS enable bit, the task-switched bit, a lock-prefix flag, the operating mode and the low bits of the effective address. It also takes a set of violation flags that other logic has already worked out: segment limit, stack segment, non-canonical address, real-mode 16-bit overrun and translation fault. From these it returns one fault code, an indication that the fault carries an error code of zero, and an `ok` signal.

The checks are combinational. A parameter selects whether the result is registered, which adds one clock of latency. The block never raises an alignment-check exception: any misaligned operand maps to general protection. Address bits above the alignment field do not affect the result, so in 64-bit mode the upper half of the address register pair has no effect.

Top module: `savec_fault_chk`

## Requirements
- R1: Fault code 1 (undefined opcode) is produced when `has_xsave` is 0, `has_compact` is 0, `os_en` is 0 or `lock_pfx` is 1. It takes priority over every other fault.
- R2: Fault code 2 (device not available) is produced when `ts_bit` is 1 and R1 does not apply.
- R3: In every mode, a misaligned address produces fault code 3 (general protection) when R1 and R2 do not apply. An address is misaligned when `eff_addr[5:0]` is not zero (default 64-byte alignment). This check comes before the limit, canonical and overrun checks, and no alignment-check code exists.
- R4: In 64-bit mode (`mode`=4), `non_canon` produces code 4 (stack fault) when `stk_seg` is 1 and code 3 otherwise. In this mode `seg_lim_viol` and `rm_overrun` are ignored.
- R5: In protected (1), compatibility (2) and virtual-8086 (3) modes, `seg_lim_viol` produces code 4 when `stk_seg` is 1 and code 3 otherwise. In these modes `non_canon` and `rm_overrun` are ignored. Mode codes 5 to 7 behave like protected mode.
- R6: In real-address mode (`mode`=0), `rm_overrun` produces code 3. In this mode `seg_lim_viol` and `non_canon` are ignored.
- R7: Fault code 5 (page fault) is produced when `pg_fault` is 1 and none of R1 to R6 applies.
- R8: `err_zero` is 1 exactly when the fault code is 3 or 4.
- R9: `ok` is 1 exactly when the fault code is 0 (none). At most one fault is reported at a time.
- R10: With `REG_OUT`=1 (the default), the outputs follow the inputs one clock later. During reset they show code 0, `ok`=1 and `err_zero`=0.
- R11: Address bits above the alignment field never affect the result. For example, `eff_addr`=0xFFFF_FFFF_0000_0040 counts as aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| has_xsave | input | 1 | Base state-save support present |
| has_compact | input | 1 | Compacted-save support present |
| os_en | input | 1 | OS has enabled extended state saving |
| ts_bit | input | 1 | Task-switched control bit |
| lock_pfx | input | 1 | Lock prefix present on the instruction |
| mode | input | 3 | 0 real, 1 protected, 2 compatibility, 3 virtual-8086, 4 64-bit |
| eff_addr | input | ADDR_W | Effective address of the save area |
| seg_lim_viol | input | 1 | Operand exceeds its segment limit |
| stk_seg | input | 1 | Operand is referenced through the stack segment |
| non_canon | input | 1 | Address is not canonical |
| rm_overrun | input | 1 | Real-mode operand extends past 0xFFFF |
| pg_fault | input | 1 | Translation reported a page fault |
| fault_code | output | 3 | 0 none, 1 undefined opcode, 2 device not available, 3 general protection, 4 stack fault, 5 page fault |
| err_zero | output | 1 | Fault pushes an error code of zero |
| ok | output | 1 | Instruction may proceed |

## Verification
Each undefined-opcode cause is applied on its own, and a lock prefix is combined with the task-switched bit to show which takes priority. Misaligned addresses are tried in every mode. Some are combined with limit or canonical violations on the stack segment, which separates the alignment-first ordering from the stack-fault path. Each violation flag is raised in every mode to confirm that it only counts in the modes that own it. An address with only high bits set shows that those bits are ignored, and a page fault combined with a misaligned address shows the ordering of the last two priority levels.

// File: rtl/savec_fault_pkg.sv
package savec_fault_pkg;
  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_UD   = 3'd1,
    FC_NM   = 3'd2,
    FC_GP   = 3'd3,
    FC_SS   = 3'd4,
    FC_PF   = 3'd5
  } fault_e;

  localparam logic [2:0] MD_REAL   = 3'd0;
  localparam logic [2:0] MD_PROT   = 3'd1;
  localparam logic [2:0] MD_COMPAT = 3'd2;
  localparam logic [2:0] MD_V86    = 3'd3;
  localparam logic [2:0] MD_LONG   = 3'd4;
endpackage

// File: rtl/savec_gate_chk.sv
module savec_gate_chk (
  input  logic has_xsave,
  input  logic has_compact,
  input  logic os_en,
  input  logic lock_pfx,
  input  logic ts_bit,
  output logic ud_req,
  output logic nm_req
);
  // R1: any missing enable or a lock prefix makes the opcode undefined
  assign ud_req = !has_xsave || !has_compact || !os_en || lock_pfx;
  // R2: task-switched bit defers to the device
  assign nm_req = ts_bit;
endmodule

// File: rtl/savec_addr_chk.sv
module savec_addr_chk #(
  parameter int ADDR_W      = 64,
  parameter int ALIGN_BYTES = 64
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              seg_lim_viol,
  input  logic              stk_seg,
  input  logic              non_canon,
  input  logic              rm_overrun,
  output logic              gp_req,
  output logic              ss_req
);
  import savec_fault_pkg::*;
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

  logic misalign;
  logic unused_hi;

  // R11: only the alignment field is looked at
  assign misalign  = |eff_addr[ALIGN_LSB-1:0];
  assign unused_hi = ^eff_addr[ADDR_W-1:ALIGN_LSB];

  always_comb begin
    gp_req = 1'b0;
    ss_req = 1'b0;
    if (misalign) begin
      gp_req = 1'b1;                         // R3
    end else begin
      case (mode)
        MD_REAL: gp_req = rm_overrun;        // R6
        MD_LONG: begin                       // R4
          if (non_canon) begin
            ss_req = stk_seg;
            gp_req = !stk_seg;
          end
        end
        default: begin                       // R5
          if (seg_lim_viol) begin
            ss_req = stk_seg;
            gp_req = !stk_seg;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/savec_fault_pri.sv
module savec_fault_pri #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ud_req,
  input  logic       nm_req,
  input  logic       gp_req,
  input  logic       ss_req,
  input  logic       pf_req,
  output logic [2:0] fault_code,
  output logic       err_zero,
  output logic       ok
);
  import savec_fault_pkg::*;

  fault_e code_nxt;
  logic   ez_nxt;
  logic   ok_nxt;

  always_comb begin
    if (ud_req)      code_nxt = FC_UD;
    else if (nm_req) code_nxt = FC_NM;
    else if (gp_req) code_nxt = FC_GP;
    else if (ss_req) code_nxt = FC_SS;
    else if (pf_req) code_nxt = FC_PF;
    else             code_nxt = FC_NONE;
  end

  assign ez_nxt = !ud_req && !nm_req && (gp_req || ss_req);
  assign ok_nxt = !(ud_req || nm_req || gp_req || ss_req || pf_req);

  generate
    if (REG_OUT) begin : g_reg
      logic [2:0] code_q;
      logic       ez_q;
      logic       ok_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q <= FC_NONE;
          ez_q   <= 1'b0;
          ok_q   <= 1'b1;
        end else begin
          code_q <= code_nxt;
          ez_q   <= ez_nxt;
          ok_q   <= ok_nxt;
        end
      end
      assign fault_code = code_q;
      assign err_zero   = ez_q;
      assign ok         = ok_q;
    end else begin : g_comb
      assign fault_code = code_nxt;
      assign err_zero   = ez_nxt;
      assign ok         = ok_nxt;
    end
  endgenerate

  a_r1_ud_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ud_req |-> code_nxt == FC_UD);
  a_r2_nm_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!ud_req && nm_req) |-> code_nxt == FC_NM);
  a_r3_gp_over_ss: assert property (@(posedge clk) disable iff (!rst_n)
    (!ud_req && !nm_req && gp_req) |-> code_nxt == FC_GP);
  a_r7_pf_last: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_req && code_nxt == FC_PF) |-> !(ud_req || nm_req || gp_req || ss_req));
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ez_nxt == (code_nxt == FC_GP || code_nxt == FC_SS));
  a_r9_ok_none: assert property (@(posedge clk) disable iff (!rst_n)
    ok_nxt == (code_nxt == FC_NONE));
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, fault_code == 3'd1, fault_code == 3'd2, fault_code == 3'd3,
              fault_code == 3'd4, fault_code == 3'd5}));
endmodule

// File: rtl/savec_fault_chk.sv
module savec_fault_chk #(
  parameter int ADDR_W      = 64,
  parameter int ALIGN_BYTES = 64,
  parameter bit REG_OUT     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              has_xsave,
  input  logic              has_compact,
  input  logic              os_en,
  input  logic              ts_bit,
  input  logic              lock_pfx,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              seg_lim_viol,
  input  logic              stk_seg,
  input  logic              non_canon,
  input  logic              rm_overrun,
  input  logic              pg_fault,
  output logic [2:0]        fault_code,
  output logic              err_zero,
  output logic              ok
);
  logic ud_req, nm_req, gp_req, ss_req;

  savec_gate_chk i_gate (
    .has_xsave  (has_xsave),
    .has_compact(has_compact),
    .os_en      (os_en),
    .lock_pfx   (lock_pfx),
    .ts_bit     (ts_bit),
    .ud_req     (ud_req),
    .nm_req     (nm_req)
  );

  savec_addr_chk #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)) i_addr (
    .mode        (mode),
    .eff_addr    (eff_addr),
    .seg_lim_viol(seg_lim_viol),
    .stk_seg     (stk_seg),
    .non_canon   (non_canon),
    .rm_overrun  (rm_overrun),
    .gp_req      (gp_req),
    .ss_req      (ss_req)
  );

  savec_fault_pri #(.REG_OUT(REG_OUT)) i_pri (
    .clk       (clk),
    .rst_n     (rst_n),
    .ud_req    (ud_req),
    .nm_req    (nm_req),
    .gp_req    (gp_req),
    .ss_req    (ss_req),
    .pf_req    (pg_fault),
    .fault_code(fault_code),
    .err_zero  (err_zero),
    .ok        (ok)
  );

  a_r4_long_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && eff_addr[5:0] == 6'd0 && non_canon && stk_seg)
    |-> (ud_req || nm_req || ss_req));
  a_r6_real_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && eff_addr[5:0] == 6'd0 && !rm_overrun) |-> !(gp_req || ss_req));
endmodule

// File: tb/test_savec_fault_chk.sv
module test_savec_fault_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        has_xsave, has_compact, os_en, ts_bit, lock_pfx;
  logic [2:0]  mode;
  logic [63:0] eff_addr;
  logic        seg_lim_viol, stk_seg, non_canon, rm_overrun, pg_fault;
  logic [2:0]  fault_code;
  logic        err_zero, ok;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  savec_fault_chk i_savec_fault_chk (
    .clk(clk), .rst_n(rst_n), .has_xsave(has_xsave), .has_compact(has_compact),
    .os_en(os_en), .ts_bit(ts_bit), .lock_pfx(lock_pfx), .mode(mode),
    .eff_addr(eff_addr), .seg_lim_viol(seg_lim_viol), .stk_seg(stk_seg),
    .non_canon(non_canon), .rm_overrun(rm_overrun), .pg_fault(pg_fault),
    .fault_code(fault_code), .err_zero(err_zero), .ok(ok)
  );

  task automatic clean(input logic [2:0] m);
    has_xsave = 1; has_compact = 1; os_en = 1; ts_bit = 0; lock_pfx = 0;
    mode = m; eff_addr = 64'h1000; seg_lim_viol = 0; stk_seg = 0;
    non_canon = 0; rm_overrun = 0; pg_fault = 0;
  endtask

  task automatic compare(input logic [2:0] exp, input string tag);
    logic exp_ez, exp_ok;
    exp_ez = (exp == 3'd3) || (exp == 3'd4);
    exp_ok = (exp == 3'd0);
    n_chk++;
    if (fault_code !== exp || err_zero !== exp_ez || ok !== exp_ok) begin
      n_fail++;
      $display("FAIL %s: code=%0d ez=%0d ok=%0d expected code=%0d ez=%0d ok=%0d",
               tag, fault_code, err_zero, ok, exp, exp_ez, exp_ok);
    end
  endtask

  // inputs set just after a falling edge; one register stage; sample at next falling edge
  task automatic step(input logic [2:0] exp, input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(exp, tag);
  endtask

  task automatic t_reset;
    clean(3'd1); ts_bit = 1;
    @(posedge clk); @(negedge clk);
    compare(3'd0, "R10 reset state");
    rst_n = 1'b1;
    step(3'd2, "R10 one-cycle latency after reset");
  endtask

  task automatic t_ud;
    clean(3'd1); has_xsave = 0;   step(3'd1, "R1 no base support");
    clean(3'd4); has_compact = 0; step(3'd1, "R1 no compacted support");
    clean(3'd0); os_en = 0;       step(3'd1, "R1 os enable clear");
    clean(3'd1); lock_pfx = 1; ts_bit = 1; eff_addr = 64'h3; pg_fault = 1;
    step(3'd1, "R1 lock beats all");
  endtask

  task automatic t_nm;
    clean(3'd4); ts_bit = 1; eff_addr = 64'h8; non_canon = 1;
    step(3'd2, "R2 task switched over misalign");
  endtask

  task automatic t_align;
    for (int m = 0; m < 5; m++) begin
      clean(m[2:0]); eff_addr = 64'h1020; stk_seg = 1; seg_lim_viol = 1; non_canon = 1;
      step(3'd3, $sformatf("R3 misaligned in mode %0d", m));
    end
    clean(3'd1); eff_addr = 64'h1001; step(3'd3, "R3 one byte off");
    clean(3'd4); eff_addr = 64'hFFFF_FFFF_0000_0040; step(3'd0, "R11 high bits ignored");
  endtask

  task automatic t_long;
    clean(3'd4); non_canon = 1;             step(3'd3, "R4 non-canonical data");
    clean(3'd4); non_canon = 1; stk_seg = 1; step(3'd4, "R4 non-canonical stack");
    clean(3'd4); seg_lim_viol = 1; rm_overrun = 1; step(3'd0, "R4 limit ignored in 64-bit");
  endtask

  task automatic t_prot;
    for (int m = 1; m < 4; m++) begin
      clean(m[2:0]); seg_lim_viol = 1;              step(3'd3, $sformatf("R5 limit data mode %0d", m));
      clean(m[2:0]); seg_lim_viol = 1; stk_seg = 1; step(3'd4, $sformatf("R5 limit stack mode %0d", m));
    end
    clean(3'd2); non_canon = 1; rm_overrun = 1; step(3'd0, "R5 canonical ignored");
    clean(3'd6); seg_lim_viol = 1; stk_seg = 1;   step(3'd4, "R5 spare mode acts protected");
  endtask

  task automatic t_real;
    clean(3'd0); rm_overrun = 1; stk_seg = 1; step(3'd3, "R6 overrun");
    clean(3'd0); seg_lim_viol = 1; non_canon = 1; step(3'd0, "R6 other flags ignored");
  endtask

  task automatic t_pf;
    clean(3'd4); pg_fault = 1;                    step(3'd5, "R7 page fault");
    clean(3'd0); pg_fault = 1; eff_addr = 64'h10; step(3'd3, "R7 misalign before page fault");
    clean(3'd1);                                  step(3'd0, "R9 clean instruction ok");
  endtask

  initial begin
    #4_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: expected=finish actual=timeout");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_ud();
    t_nm();
    t_align();
    t_long();
    t_prot();
    t_real();
    t_pf();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule